// File: doc/BRIEF.md
# Parallel-Prefix Carry-Lookahead Adder

This block adds two unsigned N-bit operands and a single carry input, producing an N-bit sum and a carry output. It has no clock and no state. Every operand position is first reduced to a (generate, propagate) pair. The pairs then flow through a prefix network that is built recursively from one associative merge operator. That network delivers the carry into every position at once. A final XOR layer forms the sum bits in parallel.

The carry input enters the network as an extra lowest element, one place below bit 0. It is treated as a pure generate term with propagate held low. Inclusive prefix k of that (N+1)-element sequence is therefore the carry into bit k, and prefix N is the carry output. Each recursion level halves the number of elements, so the network is log2(N+1) levels deep, and each level adds at most one operator per element pair. The block is meant to be dropped into datapaths that need a fast, moderately small adder of any width of at least one bit.

Top module: `cla_adder`

## Requirements
- R1: The N+1 bit value {cout, sum} always equals the arithmetic sum a + b + cin, for N = 1, 5, 8 and 32.
- R2: A position whose two operand bits are both 1 generates a carry into the next position, whatever the carry arriving at it.
- R3: A position with at least one operand bit at 1 passes an arriving carry on to the next position, and a generating position is always also a propagating one.
- R4: The carry input acts as the element below bit 0. With both operands zero, sum equals cin in bit 0 and cout is 0. With a all ones, b zero and cin 1, sum is zero and cout is 1.
- R5: The merge of an upper span over a lower span yields generate = upper generate OR (upper propagate AND lower generate) and propagate = upper propagate AND lower propagate. Any prefix that ends on a generating element carries out, and a prefix propagates only if its top element does.
- R6: Each sum bit is a XOR b XOR the carry into that bit, so with a = 0 and cin = 0 the sum equals b and cout is 0.
- R7: N is a parameter of at least 1. Widths that are not a power of two produce correct results, and a width below 1 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of the result |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
Whenever the inputs settle, the assertions re-check the arithmetic identity of the outputs. They also check that generating positions always propagate, that the prefix network never loses a generate or invents a propagate, and that a top-bit generate always reaches cout. Only the bench's scenarios can show that these properties hold across complete operand spaces. It sweeps every input combination for widths 1, 5 and 8. It also drives directed carry chains, where a single carry travels the full width or is created in one place. For the 32-bit width it runs pseudo-random vectors as well.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // One element of the prefix sequence: generate and propagate of a span.
   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // Associative merge of an upper span over the span just below it.
   function automatic gp_t gp_merge(gp_t hi, gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

   // Number of recursion levels the prefix network needs for W elements.
   function automatic int unsigned prefix_levels(int unsigned w);
      int unsigned lv;
      int unsigned n;
      lv = 0;
      n  = w;
      while (n > 1) begin
         n  = (n + 1) / 2;
         lv = lv + 1;
      end
      return lv;
   endfunction

endpackage

// File: rtl/cla_gp_encode.sv
module cla_gp_encode #(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0]         a,
   input  logic [N-1:0]         b,
   input  logic                 cin,
   output cla_pkg::gp_t [N:0]   elem
);
   import cla_pkg::*;

   generate
      if (N < 1) begin : g_bad_width
         $error("cla_gp_encode: N must be at least 1");
      end
   endgenerate

   // Element 0 models the carry input: it generates but never propagates.
   assign elem[0].g = cin;
   assign elem[0].p = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign elem[i+1].g = a[i] & b[i];
         assign elem[i+1].p = a[i] | b[i];
      end
   endgenerate

   // R3: a generating position must also propagate.
   always_comb begin
      if (!$isunknown({a, b})) begin
         for (int i = 1; i <= N; i++) begin
            p_gen_implies_prop_r3 : assert (!elem[i].g || elem[i].p)
               else $error("generate without propagate at element %0d", i);
         end
         p_cin_never_propagates_r4 : assert (elem[0].p == 1'b0)
            else $error("carry-in element propagates");
      end
   end

endmodule

// File: rtl/cla_prefix_net.sv
module cla_prefix_net #(
   parameter int unsigned W = 33
) (
   input  cla_pkg::gp_t [W-1:0] x,
   output cla_pkg::gp_t [W-1:0] y
);
   import cla_pkg::*;

   localparam int unsigned H     = W / 2;
   localparam int unsigned NEVEN = (W - 1) / 2;

   generate
      if (W < 1) begin : g_bad_width
         $error("cla_prefix_net: W must be at least 1");
      end

      if (W == 1) begin : g_leaf
         assign y = x;
      end else begin : g_node
         gp_t [H-1:0] pair_gp;
         gp_t [H-1:0] sub_gp;

         // Level down: merge adjacent pairs.
         for (genvar j = 0; j < H; j++) begin : g_pair
            assign pair_gp[j] = gp_merge(x[2*j+1], x[2*j]);
         end

         // Recurse on the half-size sequence.
         cla_prefix_net #(.W(H)) u_sub (
            .x (pair_gp),
            .y (sub_gp)
         );

         // Level up: odd positions come straight back, even ones need one merge.
         assign y[0] = x[0];
         for (genvar j = 0; j < H; j++) begin : g_odd
            assign y[2*j+1] = sub_gp[j];
         end
         for (genvar j = 1; j <= NEVEN; j++) begin : g_even
            assign y[2*j] = gp_merge(x[2*j], sub_gp[j-1]);
         end
      end
   endgenerate

   // R5: a prefix ending on a generating element generates; a prefix
   // propagates only if its top element does; the first prefix is the element.
   always_comb begin
      if (!$isunknown(x)) begin
         for (int k = 0; k < W; k++) begin
            p_gen_kept_r5 : assert (!x[k].g || y[k].g)
               else $error("prefix %0d lost a generate", k);
            p_prop_needs_top_r5 : assert (!y[k].p || x[k].p)
               else $error("prefix %0d propagates past a blocking element", k);
         end
         p_first_prefix_r5 : assert (y[0] == x[0])
            else $error("first prefix differs from its element");
      end
   end

endmodule

// File: rtl/cla_sum_form.sv
module cla_sum_form #(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0]       a,
   input  logic [N-1:0]       b,
   input  cla_pkg::gp_t [N:0] pre,
   output logic [N-1:0]       sum,
   output logic               cout
);
   import cla_pkg::*;

   generate
      for (genvar i = 0; i < N; i++) begin : g_sum
         assign sum[i] = a[i] ^ b[i] ^ pre[i].g;
      end
   endgenerate

   assign cout = pre[N].g;

   // R4: the whole sequence starts with a non-propagating element, so no
   // prefix can be in the propagate state.
   always_comb begin
      if (!$isunknown(pre)) begin
         for (int k = 0; k <= N; k++) begin
            p_no_open_prefix_r4 : assert (pre[k].p == 1'b0)
               else $error("prefix %0d still propagates", k);
         end
      end
   end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         cin,
   output logic [N-1:0] sum,
   output logic         cout
);
   import cla_pkg::*;

   localparam int unsigned NE     = N + 1;
   localparam int unsigned LEVELS = prefix_levels(NE);

   generate
      if (N < 1) begin : g_bad_width
         $error("cla_adder: N must be at least 1");
      end
      if (LEVELS > 32) begin : g_bad_depth
         $error("cla_adder: prefix depth out of range");
      end
   endgenerate

   gp_t [N:0] elem;
   gp_t [N:0] pre;

   cla_gp_encode #(.N(N)) u_encode (
      .a    (a),
      .b    (b),
      .cin  (cin),
      .elem (elem)
   );

   cla_prefix_net #(.W(NE)) u_prefix (
      .x (elem),
      .y (pre)
   );

   cla_sum_form #(.N(N)) u_sum (
      .a    (a),
      .b    (b),
      .pre  (pre),
      .sum  (sum),
      .cout (cout)
   );

   // R1: arithmetic identity. R2: a top-bit generate always reaches cout.
   // R6: bit 0 depends only on a, b and cin.
   always_comb begin
      if (!$isunknown({a, b, cin, sum, cout})) begin
         p_sum_matches_r1 : assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + NE'(cin)))
            else $error("sum mismatch");
         p_top_generate_r2 : assert (!(a[N-1] & b[N-1]) || cout)
            else $error("top generate did not reach cout");
         p_bit0_xor_r6 : assert (sum[0] == (a[0] ^ b[0] ^ cin))
            else $error("bit 0 sum wrong");
      end
   end

endmodule

// File: tb/cla_adder_bench.sv
module cla_adder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 195000;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [31:0] a32, b32, s32;
   logic        c32, co32;
   logic [7:0]  a8, b8, s8;
   logic        c8, co8;
   logic [4:0]  a5, b5, s5;
   logic        c5, co5;
   logic [0:0]  a1, b1, s1;
   logic        c1, co1;

   cla_adder #(.N(32)) u_cla_adder (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
   cla_adder #(.N(8))  u_w8        (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
   cla_adder #(.N(5))  u_w5        (.a(a5),  .b(b5),  .cin(c5),  .sum(s5),  .cout(co5));
   cla_adder #(.N(1))  u_w1        (.a(a1),  .b(b1),  .cin(c1),  .sum(s1),  .cout(co1));

   task automatic chk(string tag, longint unsigned act, longint unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run32(string tag, logic [31:0] a, logic [31:0] b, logic ci);
      longint unsigned exp;
      @(posedge clk);
      a32 = a; b32 = b; c32 = ci;
      @(negedge clk);
      exp = longint'(a) + longint'(b) + longint'(ci);
      chk(tag, {31'd0, co32, s32}, exp);
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr_a;
      logic [31:0] lfsr_b;
      a32 = '0; b32 = '0; c32 = 1'b0;
      a8 = '0; b8 = '0; c8 = 1'b0;
      a5 = '0; b5 = '0; c5 = 1'b0;
      a1 = '0; b1 = '0; c1 = 1'b0;
      repeat (2) @(posedge clk);

      // Idle state: all-zero inputs give all-zero outputs (R4).
      @(negedge clk);
      chk("R4 idle zero", {31'd0, co32, s32}, 0);

      // R4: carry input alone, and full-width ripple from the carry input.
      run32("R4 cin only", 32'h0, 32'h0, 1'b1);
      run32("R4 ones+cin ripple", 32'hFFFF_FFFF, 32'h0, 1'b1);
      run32("R4 all ones both + cin", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

      // R2: a single generate at bit k carries into bit k+1.
      for (int k = 0; k < 32; k++)
         run32("R2 single generate", 32'h1 << k, 32'h1 << k, 1'b0);

      // R3: generate at bit 0 travels through propagating positions above it.
      for (int k = 1; k < 32; k++)
         run32("R3 propagate chain", (32'h1 << k) - 1, 32'h1, 1'b0);

      // R5: generate blocked by a non-propagating position in the middle.
      run32("R5 blocked chain", 32'hFFFE_FFFF, 32'h0000_0001, 1'b0);
      run32("R5 generate then kill", 32'h0000_FFFF, 32'h0000_FFFF, 1'b1);

      // R6: no carries at all, so sum is b.
      run32("R6 no carry", 32'h0, 32'hA5C3_0F96, 1'b0);
      run32("R6 disjoint bits", 32'h5555_5555, 32'hAAAA_AAAA, 1'b0);

      // R1: pseudo-random 32-bit vectors.
      lfsr_a = 32'h1234_5678;
      lfsr_b = 32'h9E37_79B9;
      for (int n = 0; n < 1000; n++) begin
         lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
         lfsr_b = lfsr_b * 32'd1664525 + 32'd1013904223;
         run32("R1 random 32", lfsr_a, lfsr_b, lfsr_a[7]);
      end

      // R7: exhaustive 1-bit width.
      for (int v = 0; v < 8; v++) begin
         @(posedge clk);
         a1 = v[0]; b1 = v[1]; c1 = v[2];
         @(negedge clk);
         chk("R7 width 1", {co1, s1}, v[0] + v[1] + v[2]);
      end

      // R7: exhaustive 5-bit width (not a power of two).
      for (int v = 0; v < 2048; v++) begin
         @(posedge clk);
         a5 = v[4:0]; b5 = v[9:5]; c5 = v[10];
         @(negedge clk);
         chk("R7 width 5", {co5, s5}, v[4:0] + v[9:5] + v[10]);
      end

      // R1: exhaustive 8-bit width.
      for (int v = 0; v < 131072; v++) begin
         @(posedge clk);
         a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
         @(negedge clk);
         chk("R1 width 8", {co8, s8}, v[7:0] + v[15:8] + v[16]);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule